// File: doc/BRIEF.md
# Two-Level Hierarchical 32-Input Multiplexer

This block selects one of 32 data inputs and presents it at a single output. The selection happens in two levels. The three low select bits go unchanged to four identical 8-input slices. Each slice merges its own select decoding with the data in a single AND-OR plane. The two high select bits pass through a small binary decoder, which enables exactly one slice. A slice that is not enabled drives all zeros, so the four slice outputs are simply ORed to form the result.

The path is purely combinational. The output follows the select and data inputs without any clock. The data width per input is a parameter, and a bus-wide build repeats the same 1-bit slice once per bit. Input `k` occupies bits `[k*DATA_W +: DATA_W]` of the flat data vector.

Top module: `hier_mux32`

## Requirements
- R1: For every value of `sel`, read as an unsigned 5-bit index k, the output `y` equals data input k.
- R2: `sel[2:0]` chooses the same lane position inside every slice, and `sel[4:3]` chooses the slice. The slice-to-input mapping is: 00 covers inputs 0-7, 01 covers 8-15, 10 covers 16-23 and 11 covers 24-31.
- R3: For any select value exactly one slice is enabled. The output is therefore 1 when only that slice's eight inputs are all ones, and 0 when only the inputs of the other slices are ones.
- R4: A slice that is not enabled contributes zero. Changing any unselected input leaves `y` unchanged.
- R5: In a bus-wide build (DATA_W > 1), bit i of the chosen input drives output bit i, with no crossing between bit positions.
- R6: The path holds no state. A change on the selected input or on `sel` appears on `y` with no clock edge involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| d_in | input | NUM_SLICES*SLICE_IN*DATA_W (32) | Flat data vector; input k at bits [k*DATA_W +: DATA_W] |
| sel | input | log2(NUM_SLICES*SLICE_IN) (5) | Unsigned index of the input to pass |
| y | output | DATA_W (1) | Selected data |

## Verification
The bench sweeps all 32 select values against an indexing model, using several random data vectors and walking-one and walking-zero patterns. A swapped or misrouted bank decode would show up as a whole block of eight inputs landing in the wrong place. Per-bank fill patterns expose a decoder that enables two slices, or none: the OR then picks up foreign ones, or drops the selected one. Toggling every unselected input catches a disabled slice that leaks its data. A 4-bit-wide instance with distinct per-bit patterns catches bit lanes that are crossed or tied together.

// File: rtl/hier_mux32_pkg.sv
package hier_mux32_pkg;

    localparam int HM_SLICES = 4;
    localparam int HM_LANES  = 8;
    localparam int HM_DATA_W = 1;

    // Index width for n choices, never below one bit.
    function automatic int idx_bits(input int n);
        int b;
        b = 1;
        while ((1 << b) < n) b++;
        return b;
    endfunction

endpackage

// File: rtl/hm_bank_decoder.sv
module hm_bank_decoder #(
    parameter int OUT_N = 4,
    parameter int IN_W  = hier_mux32_pkg::idx_bits(OUT_N)
) (
    input  logic             en,
    input  logic [IN_W-1:0]  code,
    output logic [OUT_N-1:0] hot
);

    for (genvar k = 0; k < OUT_N; k++) begin : g_line
        assign hot[k] = en && (code == IN_W'(k));
    end

    always_comb begin
        if (en) assert_dec_onehot_R3: assert ($onehot(hot))
            else $error("decoder output not one-hot");
    end

endmodule

// File: rtl/hm_lane_slice.sv
module hm_lane_slice #(
    parameter int LANES  = 8,
    parameter int DATA_W = 1,
    parameter int SEL_W  = hier_mux32_pkg::idx_bits(LANES)
) (
    input  logic                    en,
    input  logic [SEL_W-1:0]        lane,
    input  logic [LANES*DATA_W-1:0] data,
    output logic [DATA_W-1:0]       y
);

    // One AND-OR plane per data bit; the lane decode is folded into each AND term.
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        logic [LANES-1:0] term;
        for (genvar l = 0; l < LANES; l++) begin : g_term
            assign term[l] = en && (lane == SEL_W'(l)) && data[l*DATA_W + b];
        end
        assign y[b] = |term;
    end

    always_comb begin
        if (!en) assert_off_slice_zero_R4: assert (y == '0)
            else $error("disabled slice drives nonzero");
        else assert_slice_pick_R5: assert (y == data[lane*DATA_W +: DATA_W])
            else $error("slice output differs from chosen lane");
    end

endmodule

// File: rtl/hier_mux32.sv
module hier_mux32 #(
    parameter int NUM_SLICES = hier_mux32_pkg::HM_SLICES,
    parameter int SLICE_IN   = hier_mux32_pkg::HM_LANES,
    parameter int DATA_W     = hier_mux32_pkg::HM_DATA_W,
    parameter int NUM_IN     = NUM_SLICES * SLICE_IN,
    parameter int SEL_W      = hier_mux32_pkg::idx_bits(NUM_IN)
) (
    input  logic [NUM_IN*DATA_W-1:0] d_in,
    input  logic [SEL_W-1:0]         sel,
    output logic [DATA_W-1:0]        y
);

    localparam int LANE_W = hier_mux32_pkg::idx_bits(SLICE_IN);
    localparam int BANK_W = hier_mux32_pkg::idx_bits(NUM_SLICES);

    logic [BANK_W-1:0]     bank_sel;
    logic [LANE_W-1:0]     lane_sel;
    logic [NUM_SLICES-1:0] bank_en;
    logic [DATA_W-1:0]     slice_y [NUM_SLICES];

    assign lane_sel = sel[LANE_W-1:0];
    assign bank_sel = sel[LANE_W +: BANK_W];

    hm_bank_decoder #(.OUT_N(NUM_SLICES), .IN_W(BANK_W)) u_dec (
        .en   (1'b1),
        .code (bank_sel),
        .hot  (bank_en)
    );

    for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
        hm_lane_slice #(.LANES(SLICE_IN), .DATA_W(DATA_W), .SEL_W(LANE_W)) u_slice (
            .en   (bank_en[s]),
            .lane (lane_sel),
            .data (d_in[s*SLICE_IN*DATA_W +: SLICE_IN*DATA_W]),
            .y    (slice_y[s])
        );
    end

    always_comb begin
        y = '0;
        for (int s = 0; s < NUM_SLICES; s++) y |= slice_y[s];
    end

    always_comb begin
        assert_one_bank_R3: assert ($countones(bank_en) == 1)
            else $error("bank enable count wrong");
        assert_index_R1: assert (y == d_in[sel*DATA_W +: DATA_W])
            else $error("output differs from indexed input");
        assert_bank_map_R2: assert (bank_en[bank_sel] && y == slice_y[bank_sel])
            else $error("wrong slice carries the output");
    end

endmodule

// File: tb/hier_mux32_bench.sv
module hier_mux32_bench;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic [31:0]  d1;
    logic [4:0]   s1;
    logic         y1;
    logic [127:0] d4;
    logic [4:0]   s4;
    logic [3:0]   y4;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    hier_mux32 u_hier_mux32 (.d_in(d1), .sel(s1), .y(y1));
    hier_mux32 #(.DATA_W(4)) u_hier_mux32_w4 (.d_in(d4), .sel(s4), .y(y4));

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic settle;
        @(posedge clk);
        #1;
    endtask

    task automatic t_idle_zero;  // all-zero data gives zero for any select (R1)
        @(negedge clk); d1 = '0; s1 = 5'd17;
        settle();
        chk("R1 zero data", {3'b0, y1}, 4'h0);
    endtask

    task automatic t_sweep_random;  // R1 every index against indexing model
        for (int v = 0; v < 6; v++) begin
            logic [31:0] pat;
            pat = $urandom;
            for (int k = 0; k < 32; k++) begin
                @(negedge clk); d1 = pat; s1 = 5'(k);
                settle();
                chk("R1 random sweep", {3'b0, y1}, {3'b0, pat[k]});
            end
        end
    endtask

    task automatic t_walk;  // R2 walking one / walking zero locate each input
        for (int k = 0; k < 32; k++) begin
            for (int j = 0; j < 32; j++) begin
                @(negedge clk); d1 = 32'(1) << k; s1 = 5'(j);
                settle();
                chk("R2 walking one", {3'b0, y1}, {3'b0, (j == k)});
            end
        end
        for (int k = 0; k < 32; k += 5) begin
            @(negedge clk); d1 = ~(32'(1) << k); s1 = 5'(k);
            settle();
            chk("R2 walking zero", {3'b0, y1}, 4'h0);
        end
        // bank 00 -> inputs 0-7, bank 10 -> inputs 16-23
        @(negedge clk); d1 = 32'h0000_00FF; s1 = 5'b00_011;
        settle();
        chk("R2 bank 00", {3'b0, y1}, 4'h1);
        @(negedge clk); d1 = 32'h00FF_0000; s1 = 5'b10_110;
        settle();
        chk("R2 bank 10", {3'b0, y1}, 4'h1);
    endtask

    task automatic t_single_bank;  // R3 only the addressed slice reaches y
        for (int b = 0; b < 4; b++) begin
            for (int k = 0; k < 32; k++) begin
                @(negedge clk); d1 = 32'hFF << (8 * b); s1 = 5'(k);
                settle();
                chk("R3 bank fill", {3'b0, y1}, {3'b0, ((k / 8) == b)});
            end
        end
    endtask

    task automatic t_isolation;  // R4 unselected inputs cannot move y
        for (int k = 0; k < 32; k += 3) begin
            logic [31:0] base;
            logic        ref_bit;
            base = $urandom;
            ref_bit = base[k];
            for (int t = 0; t < 4; t++) begin
                logic [31:0] noise;
                noise = $urandom;
                noise[k] = 1'b0;
                @(negedge clk); d1 = base ^ noise; s1 = 5'(k);
                settle();
                chk("R4 unselected toggled", {3'b0, y1}, {3'b0, ref_bit});
            end
        end
    endtask

    task automatic t_bus;  // R5 bit i of chosen input drives bit i
        logic [127:0] pat;
        pat = {$urandom, $urandom, $urandom, $urandom};
        for (int k = 0; k < 32; k++) begin
            @(negedge clk); d4 = pat; s4 = 5'(k);
            settle();
            chk("R5 bus random", y4, pat[k*4 +: 4]);
        end
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); d4 = '0; d4[13*4 + i] = 1'b1; s4 = 5'd13;
            settle();
            chk("R5 single bit lane", y4, 4'(1) << i);
        end
    endtask

    task automatic t_follow;  // R6 output tracks inputs without a clock edge
        @(negedge clk); d1 = '0; s1 = 5'd22;
        #1 d1[22] = 1'b1;
        #1 chk("R6 data follows", {3'b0, y1}, 4'h1);
        #1 s1 = 5'd21;
        #1 chk("R6 select follows", {3'b0, y1}, 4'h0);
    endtask

    initial begin
        d1 = '0; s1 = '0; d4 = '0; s4 = '0;
        repeat (2) @(posedge clk);
        t_idle_zero();
        t_sweep_random();
        t_walk();
        t_single_bank();
        t_isolation();
        t_bus();
        t_follow();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule